// File: doc/BRIEF.md
# Palette Write Sequencer

This block keeps a colour lookup table of 256 entries, each holding an 8-bit red, green and blue value, and loads it through a small 32-bit register window. Software first writes a starting entry number to the pointer register. It then streams colour bytes into the colour register. The bytes go to red, then green, then blue of the pointed entry. After the blue byte the pointer moves on to the next entry by itself, so a whole table can be loaded with one pointer write followed by a run of colour writes.

Scanout logic reads the table through a separate lookup port. The port takes an entry number and returns that entry's packed colour without a clock edge. Each accepted colour write also raises a one-cycle update strobe that names the entry it touched. Downstream caches can use it to refresh only that entry.

Top module: `clut_loader`

## Requirements
- R1: After reset every entry reads back as {r,g,b} = 0x000000, except entry 255, which reads 0xFFFFFF. The pointer is 0 and the next colour write goes to red.
- R2: A full-width write to byte offset 0 loads the pointer from data bits [31:24] and makes red the next component.
- R3: Full-width writes to byte offset 4 store data bits [31:24] into the red, green and blue of the pointed entry, in that order, one component per write.
- R4: The write that stores blue advances the pointer by one modulo 256 (255 wraps to 0) and makes red the next component.
- R5: The read data bus is always zero. A read of either register leaves the pointer and the component order unchanged.
- R6: A write whose byte enables are not all set (bus_be other than 4'hF) changes neither the table, the pointer nor the component order.
- R7: Writes to byte offsets 8 and 12, and to any address whose two low bits are not zero, are ignored.
- R8: Each accepted colour write raises upd_valid for exactly one cycle, on the clock after the write, with upd_idx equal to the entry written.
- R9: lookup_rgb is {red[23:16], green[15:8], blue[7:0]} of entry lookup_idx, with no register in the path. A colour write shows on the port from the cycle after its write edge.
- R10: A pointer write in the middle of a colour triple discards the unfinished triple. The next colour write goes to red of the newly loaded entry, and the components already stored keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the register window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| lookup_idx | input | 8 | Entry number for the scanout lookup |
| lookup_rgb | output | 24 | Packed colour of entry lookup_idx |
| upd_valid | output | 1 | One-cycle pulse after each accepted colour write |
| upd_idx | output | 8 | Entry touched by the colour write being flagged |

## Verification
Every bus write is held for one clock, from one falling edge to the next. The pointer, the component order, the table and the update strobe all change on the rising edge in between. The bench therefore samples the strobe and the lookup port at the falling edge that ends the access, which is one cycle after the write. Lookup checks change lookup_idx and sample 1 ns later, because the read path is combinational. Ignored writes are checked twice: the strobe must stay low in that same cycle, and the following good colour write must land in the component and entry that the bench model predicts.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Order of colour components accepted by the data register
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } comp_phase_e;

    localparam int unsigned NUM_COMP = 3;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              wr_en,
    output comp_phase_e       wr_phase,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [COMP_W-1:0] wr_val,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_idx
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] WORD_PTR = WORD_W'(0);
    localparam logic [WORD_W-1:0] WORD_COL = WORD_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        comp_phase_e      phase;
        logic             upd_valid;
        logic [IDX_W-1:0] upd_idx;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic wr_ok;
    logic ptr_hit;
    logic col_hit;

    // Only whole-word, aligned writes are decoded
    assign wr_ok   = bus_sel && bus_wr && (&bus_be) && (bus_addr[1:0] == 2'b00);
    assign ptr_hit = wr_ok && (bus_addr[ADDR_W-1:2] == WORD_PTR);
    assign col_hit = wr_ok && (bus_addr[ADDR_W-1:2] == WORD_COL);

    always_comb begin
        s_d           = s_q;
        s_d.upd_valid = 1'b0;
        if (ptr_hit) begin
            s_d.idx   = bus_wdata[DATA_W-1 -: IDX_W];
            s_d.phase = PH_RED;
        end else if (col_hit) begin
            s_d.upd_valid = 1'b1;
            s_d.upd_idx   = s_q.idx;
            case (s_q.phase)
                PH_RED:  s_d.phase = PH_GRN;
                PH_GRN:  s_d.phase = PH_BLU;
                default: begin
                    s_d.phase = PH_RED;
                    s_d.idx   = s_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, phase: PH_RED, upd_valid: 1'b0, upd_idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en     = col_hit;
    assign wr_phase  = s_q.phase;
    assign wr_idx    = s_q.idx;
    assign wr_val    = bus_wdata[DATA_W-1 -: COMP_W];
    assign upd_valid = s_q.upd_valid;
    assign upd_idx   = s_q.upd_idx;

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase inside {PH_RED, PH_GRN, PH_BLU}); // R3

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_hit |=> (s_q.phase == PH_RED)
                    && (s_q.idx == $past(bus_wdata[DATA_W-1 -: IDX_W]))); // R2

    AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_hit && s_q.phase == PH_BLU) |=>
            (s_q.idx == IDX_W'($past(s_q.idx) + 1'b1)) && (s_q.phase == PH_RED)); // R4

    AST_READ_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> $stable(s_q.idx) && $stable(s_q.phase)); // R5

    AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !(&bus_be)) |=> $stable(s_q.idx) && $stable(s_q.phase)); // R6

    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        col_hit |=> upd_valid && (upd_idx == $past(s_q.idx))); // R8

    AST_UPD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !$past(col_hit)) |-> 1'b0); // R8

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  comp_phase_e                wr_phase,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [COMP_W-1:0]          wr_val,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [NUM_COMP*COMP_W-1:0] rd_rgb
);

    localparam int unsigned ENTRIES = 1 << IDX_W;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
        logic [COMP_W-1:0] plane_q [ENTRIES];
        logic              plane_we;

        assign plane_we = wr_en && (wr_phase == comp_phase_e'(c));

        // Reset leaves every entry black and the last one fully lit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    plane_q[e] <= (e == ENTRIES - 1) ? '1 : '0;
                end
            end else if (plane_we) begin
                plane_q[wr_idx] <= wr_val;
            end
        end

        // Red in the top lane, blue in the bottom lane
        assign rd_rgb[(NUM_COMP-c)*COMP_W-1 -: COMP_W] = plane_q[rd_idx];
    end

endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W/8-1:0]        bus_be,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [IDX_W-1:0]           lookup_idx,
    output logic [NUM_COMP*COMP_W-1:0] lookup_rgb,
    output logic                       upd_valid,
    output logic [IDX_W-1:0]           upd_idx
);

    logic              wr_en;
    comp_phase_e       wr_phase;
    logic [IDX_W-1:0]  wr_idx;
    logic [COMP_W-1:0] wr_val;

    clut_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .wr_en     (wr_en),
        .wr_phase  (wr_phase),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx)
    );

    clut_store #(
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_phase (wr_phase),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .rd_idx   (lookup_idx),
        .rd_rgb   (lookup_rgb)
    );

    // Register reads carry no data
    assign bus_rdata = '0;

endmodule

// File: tb/clut_loader_bench.sv
module clut_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lookup_idx = '0;
    logic [23:0] lookup_rgb;
    logic        upd_valid;
    logic [7:0]  upd_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] er [256];
    logic [7:0] eg [256];
    logic [7:0] eb [256];
    int midx = 0;
    int mph = 0;

    always #10 clk = ~clk;

    clut_loader u_clut_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .lookup_idx (lookup_idx),
        .lookup_rgb (lookup_rgb),
        .upd_valid  (upd_valid),
        .upd_idx    (upd_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_entry(input string req, input int i);
        lookup_idx = i[7:0];
        #1;
        chk(req, {8'h0, lookup_rgb}, {8'h0, er[i], eg[i], eb[i]});
    endtask

    // One access, held from a falling edge to the next
    task automatic bus_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic ptr_write(input int i);
        bus_write(4'h0, 4'hF, {i[7:0], 24'h5A5A5A});
        midx = i & 255;
        mph  = 0;
    endtask

    task automatic col_write(input string req, input logic [7:0] v);
        int t;
        t = midx;
        bus_write(4'h4, 4'hF, {v, 24'hA5C3E1});
        if (mph == 0) er[t] = v;
        else if (mph == 1) eg[t] = v;
        else eb[t] = v;
        if (mph == 2) begin
            mph = 0;
            midx = (midx + 1) & 255;
        end else begin
            mph++;
        end
        chk({req, " R8 strobe"}, {31'h0, upd_valid}, 32'h1);
        chk({req, " R8 index"}, {24'h0, upd_idx}, t);
        chk_entry({req, " R9 visible next cycle"}, t);
    endtask

    task automatic ignored_write(input string req, input logic [3:0] a, input logic [3:0] be);
        int t;
        t = midx;
        bus_write(a, be, 32'hC3000000);
        chk({req, " no strobe"}, {31'h0, upd_valid}, 32'h0);
        chk_entry({req, " entry unchanged"}, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            er[i] = (i == 255) ? 8'hFF : 8'h00;
            eg[i] = er[i];
            eb[i] = er[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        chk("R1 no strobe after reset", {31'h0, upd_valid}, 32'h0);
        for (int i = 0; i < 256; i++) chk_entry("R1 reset entry", i);
        // R1: pointer 0, red next, without any pointer write
        col_write("R1 first write to entry 0 red", 8'h11);

        // R2, R3, R9: full sweep with a computed pattern
        ptr_write(0);
        for (int i = 0; i < 256; i++) begin
            col_write("R3 red",   8'(i ^ 8'h5A));
            col_write("R3 green", 8'(i * 3));
            col_write("R3 blue",  8'(~i));
        end
        for (int i = 0; i < 256; i++) chk_entry("R3 sweep entry", i);
        chk("R4 wrapped after sweep", midx, 0);

        // R4: wrap at the last entry
        ptr_write(255);
        col_write("R4 r255", 8'h01);
        col_write("R4 g255", 8'h02);
        col_write("R4 b255", 8'h03);
        col_write("R4 wrapped red to entry 0", 8'h44);
        chk("R4 model index", midx, 0);
        chk_entry("R4 entry 255", 255);

        // R10: pointer write mid-triple
        ptr_write(10);
        col_write("R10 r10", 8'h77);
        ptr_write(20);
        col_write("R10 r20", 8'h88);
        chk_entry("R10 entry 10 kept", 10);
        chk_entry("R10 entry 20", 20);
        col_write("R10 g20", 8'h99);

        // R6: partial byte enables on both registers
        ignored_write("R6 partial colour", 4'h4, 4'h7);
        ignored_write("R6 partial colour hi", 4'h4, 4'h8);
        ignored_write("R6 partial pointer", 4'h0, 4'hE);
        col_write("R6 order kept blue20", 8'hAB);
        chk_entry("R6 entry 20", 20);

        // R7: other offsets and unaligned addresses
        ignored_write("R7 offset 8", 4'h8, 4'hF);
        ignored_write("R7 offset 12", 4'hC, 4'hF);
        ignored_write("R7 unaligned 5", 4'h5, 4'hF);
        ignored_write("R7 unaligned 1", 4'h1, 4'hF);
        col_write("R7 order kept red21", 8'hCD);

        // R5: reads return zero and change nothing
        for (int a = 0; a < 16; a += 4) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(a); bus_be = 4'hF;
            #1;
            chk("R5 read data zero", bus_rdata, 32'h0);
            @(negedge clk);
            bus_sel = 1'b0;
            chk("R5 read no strobe", {31'h0, upd_valid}, 32'h0);
        end
        col_write("R5 order kept green21", 8'hEF);
        chk_entry("R5 entry 21", 21);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule